// File: doc/BRIEF.md
# Max-Log Soft Demapper for Gray-Labelled Square QAM

This block turns one equalised complex symbol estimate into a set of bit reliabilities for a channel decoder. For every bit carried by the symbol it forms the max-log distance difference: the smallest squared distance from the estimate to a constellation point whose bit is 0, minus the smallest squared distance to a point whose bit is 1. It then scales that difference by the post-equalisation SINR, rounds the result and clamps it to a 6-bit signed output. A-priori information from the decoder plays no part in the result.

Square QAM with Gray labelling splits into two independent pulse-amplitude axes, so each axis is handled on its own coordinate. On each axis the distance difference is a closed-form, piecewise-linear function of that coordinate, so no search over constellation points and no exponentials are needed. The modulation is chosen per symbol, so a stream may mix BPSK, QPSK, 16-QAM and 64-QAM symbols on consecutive cycles. All reliabilities of a symbol leave together on one valid strobe, two clock edges after the symbol is accepted.

Top module: `llr_maxlog_unit`

## Requirements
- R1: While reset is asserted and until the first accepted symbol has passed through, `out_valid` is 0 and every lane of `llr_o` is 0.
- R2: A symbol presented with `in_valid` high at a rising edge appears with `out_valid` high exactly after the second rising edge from that one; `out_valid` is never high otherwise, and a new symbol may be accepted on every cycle.
- R3: With `mod_sel` = 0 (BPSK, levels -1 and +1, bit 1 on +1) lane 0 carries the result for the real coordinate, and the imaginary coordinate has no effect on any lane. In every mode lane 0 is the sign bit of the real axis, so a positive real coordinate never yields a negative lane 0 and a negative one never yields a positive lane 0.
- R4: With `mod_sel` = 1 (QPSK) lane 0 comes from the real axis and lane 1 from the imaginary axis, each with two levels as in R3; the distance difference is 4x.
- R5: With `mod_sel` = 2 (16-QAM) each axis has levels -3,-1,+1,+3. Numbering the levels k = 0..3 from the most negative, the axis label is k xor (k>>1) with the first bit as its MSB. Lanes 0 and 1 are the first and second bit of the real axis, lanes 2 and 3 those of the imaginary axis.
- R6: With `mod_sel` = 3 (64-QAM) each axis has levels -7..+7 in steps of 2, labelled as in R5 with k = 0..7 and three bits (first bit is the MSB). Lanes 0..2 carry the real axis bits in order, lanes 3..5 the imaginary axis bits.
- R7: Coordinates carry 4 fractional bits and the SINR is unsigned with 4 fractional bits. Each lane equals floor(lambda*rho + 1/2) in output units, where lambda is the exact max-log difference, so ties round toward positive infinity.
- R8: Results beyond the output range are clamped to 31 or -32.
- R9: Lanes above those used by the current mode are 0 on every output strobe.
- R10: While `out_valid` is low, `llr_o` holds the lanes of the last symbol delivered, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A symbol is presented this cycle |
| mod_sel | input | 2 | 0 BPSK, 1 QPSK, 2 16-QAM, 3 64-QAM |
| z_re | input | 10 | Real part of the equalised estimate, signed, 4 fractional bits |
| z_im | input | 10 | Imaginary part of the equalised estimate, signed, 4 fractional bits |
| rho | input | 8 | Post-equalisation SINR, unsigned, 4 fractional bits |
| out_valid | output | 1 | The lanes of one symbol are presented this cycle |
| llr_o | output | 36 | Six 6-bit signed reliabilities, lane i at bits [6i+5:6i] |

## Verification
The situations hardest to reach from the ports are the segment boundaries of the 64-QAM axes (magnitudes of exactly 2, 4 and 6) and the outer segments that only very large coordinates touch, together with products that land exactly on a rounding tie or just past the clamp. Directed symbols place coordinates on those boundaries, on half-way products with unit SINR and on full-scale coordinates with maximum SINR, while a long mixed stream with random gaps and a mode change on almost every symbol exercises back-to-back acceptance and output holding. The bench derives every expected lane by brute-force search over the labelled constellation points, which shares nothing with the closed-form segments of the design.

// File: rtl/llr_pkg.sv
package llr_pkg;

    // Modulation selector as presented on the mod_sel port.
    typedef enum logic [1:0] {
        MOD_BPSK  = 2'd0,
        MOD_QPSK  = 2'd1,
        MOD_QAM16 = 2'd2,
        MOD_QAM64 = 2'd3
    } mod_e;

    // Largest constellation carries three bits per axis.
    localparam int AXIS_BITS = 3;
    localparam int AXES      = 2;
    localparam int LANES     = AXIS_BITS * AXES;

endpackage

// File: rtl/llr_axis_demap.sv
// Closed-form max-log distance difference for one Gray-labelled PAM axis.
// Results carry the same number of fractional bits as the coordinate.
module llr_axis_demap
    import llr_pkg::*;
#(
    parameter int ZW = 10,
    parameter int ZF = 4,
    parameter int LW = ZW + 5
) (
    input  logic signed [ZW-1:0] x,
    input  mod_e                 mode,
    output logic signed [LW-1:0] lam_b0,
    output logic signed [LW-1:0] lam_b1,
    output logic signed [LW-1:0] lam_b2
);

    localparam int ONE_I = 1 << ZF;
    localparam logic signed [LW-1:0] C1 = LW'(ONE_I);
    localparam logic signed [LW-1:0] C2 = LW'(2 * ONE_I);
    localparam logic signed [LW-1:0] C3 = LW'(3 * ONE_I);
    localparam logic signed [LW-1:0] C4 = LW'(4 * ONE_I);
    localparam logic signed [LW-1:0] C5 = LW'(5 * ONE_I);
    localparam logic signed [LW-1:0] C6 = LW'(6 * ONE_I);

    logic signed [LW-1:0] xs;
    logic signed [LW-1:0] u;
    logic signed [LW-1:0] mag0;
    logic signed [LW-1:0] seg;
    logic signed [LW-1:0] dev;
    logic signed [LW-1:0] adev;
    logic                 neg;

    // Sign extension and magnitude of the coordinate.
    always_comb begin
        xs  = {{(LW-ZW){x[ZW-1]}}, x};
        neg = x[ZW-1];
        u   = neg ? -xs : xs;
    end

    // Sign bit: odd in x, slope grows by 4 per crossed outer level.
    always_comb begin
        seg  = '0;
        mag0 = '0;
        unique case (mode)
            MOD_BPSK, MOD_QPSK: begin
                mag0 = u <<< 2;
            end
            MOD_QAM16: begin
                if (u <= C2) mag0 = u <<< 2;
                else         mag0 = (u - C1) <<< 3;
            end
            MOD_QAM64: begin
                if (u <= C2) begin
                    mag0 = u <<< 2;
                end else if (u <= C4) begin
                    mag0 = (u - C1) <<< 3;
                end else if (u <= C6) begin
                    seg  = u - C2;
                    mag0 = (seg <<< 3) + (seg <<< 2);
                end else begin
                    mag0 = (u - C3) <<< 4;
                end
            end
        endcase
        lam_b0 = neg ? -mag0 : mag0;
    end

    // Second bit: even in x, favours the inner levels.
    always_comb begin
        lam_b1 = '0;
        unique case (mode)
            MOD_BPSK, MOD_QPSK: lam_b1 = '0;
            MOD_QAM16:          lam_b1 = (C2 - u) <<< 2;
            MOD_QAM64: begin
                if (u <= C2)      lam_b1 = (C3 - u) <<< 3;
                else if (u <= C6) lam_b1 = (C4 - u) <<< 2;
                else              lam_b1 = (C5 - u) <<< 3;
            end
        endcase
    end

    // Third bit: even in x, favours the levels 3 and 5 in magnitude.
    always_comb begin
        dev    = u - C4;
        adev   = dev[LW-1] ? -dev : dev;
        lam_b2 = '0;
        unique case (mode)
            MOD_BPSK, MOD_QPSK, MOD_QAM16: lam_b2 = '0;
            MOD_QAM64:                     lam_b2 = (C2 - adev) <<< 2;
        endcase
    end

endmodule

// File: rtl/llr_scale.sv
// Multiplies one distance difference by the SINR, rounds half up and clamps.
module llr_scale #(
    parameter int LW = 15,
    parameter int RW = 8,
    parameter int RF = 4,
    parameter int ZF = 4,
    parameter int OW = 6
) (
    input  logic signed [LW-1:0] lam,
    input  logic        [RW-1:0] rho,
    output logic signed [OW-1:0] llr
);

    localparam int PW = LW + RW + 1;
    localparam int SH = ZF + RF;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);
    localparam logic signed [PW-1:0] OMAX = (PW'(1) << (OW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] OMIN = -(PW'(1) << (OW - 1));

    logic signed [PW-1:0] lam_x;
    logic signed [PW-1:0] rho_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] q;

    always_comb begin
        lam_x = {{(RW+1){lam[LW-1]}}, lam};
        rho_x = {{(LW){1'b0}}, 1'b0, rho};
        prod  = lam_x * rho_x;
        rnd   = prod + HALF;
        q     = rnd >>> SH;
        if (q > OMAX)      llr = OMAX[OW-1:0];
        else if (q < OMIN) llr = OMIN[OW-1:0];
        else               llr = q[OW-1:0];
    end

endmodule

// File: rtl/llr_maxlog_unit.sv
// Two-stage max-log soft demapper: stage 1 forms per-bit distance
// differences and maps them to lanes, stage 2 scales, rounds and clamps.
module llr_maxlog_unit
    import llr_pkg::*;
#(
    parameter int ZW = 10,
    parameter int ZF = 4,
    parameter int RW = 8,
    parameter int RF = 4,
    parameter int OW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             mod_sel,
    input  logic signed [ZW-1:0]   z_re,
    input  logic signed [ZW-1:0]   z_im,
    input  logic [RW-1:0]          rho,
    output logic                   out_valid,
    output logic [LANES*OW-1:0]    llr_o
);

    localparam int LW = ZW + 5;

    mod_e                 mode;
    logic signed [ZW-1:0] z_ax   [AXES];
    logic signed [LW-1:0] lam_ax [AXES][AXIS_BITS];
    logic signed [LW-1:0] lam_ln [LANES];

    logic signed [LW-1:0] lam_q  [LANES];
    logic        [RW-1:0] rho_q;
    logic                 v1_q;

    logic signed [OW-1:0] llr_d  [LANES];
    logic signed [OW-1:0] llr_q  [LANES];

    assign mode    = mod_e'(mod_sel);
    assign z_ax[0] = z_re;
    assign z_ax[1] = z_im;

    // One demapper per axis.
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        llr_axis_demap #(
            .ZW(ZW),
            .ZF(ZF),
            .LW(LW)
        ) u_demap (
            .x      (z_ax[a]),
            .mode   (mode),
            .lam_b0 (lam_ax[a][0]),
            .lam_b1 (lam_ax[a][1]),
            .lam_b2 (lam_ax[a][2])
        );
    end

    // Lane order: real-axis bits first, then imaginary-axis bits.
    always_comb begin
        for (int i = 0; i < LANES; i++) lam_ln[i] = '0;
        unique case (mode)
            MOD_BPSK: begin
                lam_ln[0] = lam_ax[0][0];
            end
            MOD_QPSK: begin
                lam_ln[0] = lam_ax[0][0];
                lam_ln[1] = lam_ax[1][0];
            end
            MOD_QAM16: begin
                lam_ln[0] = lam_ax[0][0];
                lam_ln[1] = lam_ax[0][1];
                lam_ln[2] = lam_ax[1][0];
                lam_ln[3] = lam_ax[1][1];
            end
            MOD_QAM64: begin
                lam_ln[0] = lam_ax[0][0];
                lam_ln[1] = lam_ax[0][1];
                lam_ln[2] = lam_ax[0][2];
                lam_ln[3] = lam_ax[1][0];
                lam_ln[4] = lam_ax[1][1];
                lam_ln[5] = lam_ax[1][2];
            end
        endcase
    end

    // Stage 1 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q  <= 1'b0;
            rho_q <= '0;
            for (int i = 0; i < LANES; i++) lam_q[i] <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                rho_q <= rho;
                for (int i = 0; i < LANES; i++) lam_q[i] <= lam_ln[i];
            end
        end
    end

    // Scaling per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        llr_scale #(
            .LW(LW),
            .RW(RW),
            .RF(RF),
            .ZF(ZF),
            .OW(OW)
        ) u_scale (
            .lam (lam_q[i]),
            .rho (rho_q),
            .llr (llr_d[i])
        );
        assign llr_o[i*OW +: OW] = llr_q[i];
    end

    // Stage 2 register: lanes load only with a valid symbol and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int i = 0; i < LANES; i++) llr_q[i] <= '0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) begin
                for (int i = 0; i < LANES; i++) llr_q[i] <= llr_d[i];
            end
        end
    end

endmodule

// File: rtl/llr_maxlog_chk.sv
module llr_maxlog_chk
    import llr_pkg::*;
#(
    parameter int ZW = 10,
    parameter int OW = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [1:0]           mod_sel,
    input logic signed [ZW-1:0] z_re,
    input logic                 out_valid,
    input logic [LANES*OW-1:0]  llr_o
);

    logic                 v1, v2;
    logic [1:0]           m1, m2;
    logic signed [ZW-1:0] r1, r2;
    logic signed [OW-1:0] lane0;

    assign lane0 = llr_o[OW-1:0];

    // Delay line of the input side, used to relate outputs to their symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0;
            m1 <= '0;   m2 <= '0;
            r1 <= '0;   r2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1;
            m1 <= mod_sel;  m2 <= m1;
            r1 <= z_re;     r2 <= r1;
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> v2);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(llr_o));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && m2 != 2'd3) |-> (llr_o[LANES*OW-1:4*OW] == '0));

    a_r9_bpsk_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && m2 == 2'd0) |-> (llr_o[LANES*OW-1:OW] == '0));

    // R3: lane 0 follows the sign of the real coordinate in every mode.
    a_r3_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r2 > 0) |-> (lane0 >= 0));

    a_r3_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r2 < 0) |-> (lane0 <= 0));

endmodule

bind llr_maxlog_unit llr_maxlog_chk #(
    .ZW(ZW),
    .OW(OW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mod_sel   (mod_sel),
    .z_re      (z_re),
    .out_valid (out_valid),
    .llr_o     (llr_o)
);

// File: tb/sim_llr_maxlog_unit.sv
`timescale 1ns/1ps
module sim_llr_maxlog_unit;

    localparam int ZW    = 10;
    localparam int ZF    = 4;
    localparam int RW    = 8;
    localparam int RF    = 4;
    localparam int OW    = 6;
    localparam int NL    = 6;
    localparam int ONE   = 1 << ZF;
    localparam int SH    = ZF + RF;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [1:0]           mod_sel = '0;
    logic signed [ZW-1:0] z_re = '0;
    logic signed [ZW-1:0] z_im = '0;
    logic [RW-1:0]        rho = '0;
    logic                 out_valid;
    logic [NL*OW-1:0]     llr_o;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    llr_maxlog_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mod_sel(mod_sel),
        .z_re(z_re), .z_im(z_im), .rho(rho),
        .out_valid(out_valid), .llr_o(llr_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int lane_of(int i);
        logic signed [OW-1:0] v;
        v = llr_o[i*OW +: OW];
        return int'(v);
    endfunction

    // Brute-force reference: search every labelled level of the axis.
    function automatic int ref_lane(int mode, int re, int im, int rr, int lane);
        int bpa, nl, x, bit_i, m, d0, d1, lam, p, r;
        bpa = (mode <= 1) ? 1 : (mode == 2 ? 2 : 3);
        nl  = (mode == 0) ? 1 : 2 * bpa;
        if (lane >= nl) return 0;
        x     = (lane / bpa == 0) ? re : im;
        bit_i = lane % bpa;
        m     = 1 << bpa;
        d0    = 32'h3fffffff;
        d1    = 32'h3fffffff;
        for (int k = 0; k < m; k++) begin
            int a, g, bv, d;
            a  = (2 * k - m + 1) * ONE;
            g  = k ^ (k >> 1);
            bv = (g >> (bpa - 1 - bit_i)) & 1;
            d  = (x - a) * (x - a);
            if (bv == 1) begin if (d < d1) d1 = d; end
            else         begin if (d < d0) d0 = d; end
        end
        lam = (d0 - d1) / ONE;
        p   = lam * rr;
        r   = (p + (1 << (SH - 1))) >>> SH;
        if (r > 31)  r = 31;
        if (r < -32) r = -32;
        return r;
    endfunction

    function automatic string mode_tag(int mode);
        case (mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    typedef struct {
        int mode;
        int l [NL];
    } exp_t;

    exp_t q_exp [$];
    bit   m_v1 = 0;
    bit   m_ov = 0;
    int   m_mode = 0;
    int   m_llr [NL] = '{default: 0};

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_v1 = 0;
            m_ov = 0;
            q_exp.delete();
            for (int i = 0; i < NL; i++) m_llr[i] = 0;
        end else begin
            m_ov = m_v1;
            if (m_v1 && q_exp.size() > 0) begin
                exp_t e;
                e = q_exp.pop_front();
                m_mode = e.mode;
                for (int i = 0; i < NL; i++) m_llr[i] = e.l[i];
            end
            m_v1 = in_valid;
            if (in_valid) begin
                exp_t e;
                e.mode = int'(mod_sel);
                for (int i = 0; i < NL; i++)
                    e.l[i] = ref_lane(int'(mod_sel), int'(z_re), int'(z_im), int'(rho), i);
                q_exp.push_back(e);
            end
        end
    end

    // Comparison on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "out_valid", int'(out_valid), int'(m_ov));
            for (int i = 0; i < NL; i++) begin
                if (m_ov) begin
                    int bpa, nl;
                    bpa = (m_mode <= 1) ? 1 : (m_mode == 2 ? 2 : 3);
                    nl  = (m_mode == 0) ? 1 : 2 * bpa;
                    chk(i < nl ? mode_tag(m_mode) : "R9", $sformatf("lane%0d", i),
                        lane_of(i), m_llr[i]);
                end else begin
                    chk("R10", $sformatf("held lane%0d", i), lane_of(i), m_llr[i]);
                end
            end
        end
    end

    // Drive one symbol, then idle until its lanes are on the output.
    task automatic send(int mode, int re, int im, int rr);
        @(negedge clk);
        in_valid = 1'b1;
        mod_sel  = 2'(mode);
        z_re     = ZW'(re);
        z_im     = ZW'(im);
        rho      = RW'(rr);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "llr in reset", int'(llr_o == '0), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "llr after reset", int'(llr_o == '0), 1);

        // R3: BPSK, re=-1.5, rho=2.0 -> 4*-1.5*2 = -12; imaginary ignored
        send(0, -24, 200, 32);
        chk("R3", "bpsk lane0", lane_of(0), -12);
        chk("R9", "bpsk upper lanes", int'(llr_o[NL*OW-1:OW] == '0), 1);
        send(0, -24, -300, 32);
        chk("R3", "bpsk lane0 with other imag", lane_of(0), -12);

        // R4: QPSK re=0.75, im=-3.0, rho=1.0 -> 3, -12
        send(1, 12, -48, 16);
        chk("R4", "qpsk lane0", lane_of(0), 3);
        chk("R4", "qpsk lane1", lane_of(1), -12);

        // R7: half-way ties, 0.5 -> 1 and -0.5 -> 0
        send(1, 2, -2, 16);
        chk("R7", "tie positive", lane_of(0), 1);
        chk("R7", "tie negative", lane_of(1), 0);

        // R5: 16-QAM re=3.0, im=-0.5, rho=1.0 -> 16,-4,-2,6
        send(2, 48, -8, 16);
        chk("R5", "qam16 lane0", lane_of(0), 16);
        chk("R5", "qam16 lane1", lane_of(1), -4);
        chk("R5", "qam16 lane2", lane_of(2), -2);
        chk("R5", "qam16 lane3", lane_of(3), 6);

        // R6: 64-QAM re=5.0, im=1.0, rho=0.5 -> 18,-2,2,2,8,-2
        send(3, 80, 16, 8);
        chk("R6", "qam64 lane0", lane_of(0), 18);
        chk("R6", "qam64 lane1", lane_of(1), -2);
        chk("R6", "qam64 lane2", lane_of(2), 2);
        chk("R6", "qam64 lane3", lane_of(3), 2);
        chk("R6", "qam64 lane4", lane_of(4), 8);
        chk("R6", "qam64 lane5", lane_of(5), -2);

        // R6: segment boundaries 2, 4, 6 on both axes
        send(3, 2 * ONE, -4 * ONE, 16);
        send(3, 6 * ONE, -6 * ONE, 16);
        send(3, 4 * ONE, 2 * ONE, 16);

        // R8: clamp at full scale
        send(3, 496, -496, 255);
        chk("R8", "clamp high lane0", lane_of(0), 31);
        chk("R8", "clamp low lane1", lane_of(1), -32);
        chk("R8", "clamp low lane3", lane_of(3), -32);

        // R10: idle inputs change while nothing is accepted
        send(1, 40, -40, 16);
        repeat (5) begin
            @(negedge clk);
            z_re = ZW'($urandom);
            z_im = ZW'($urandom);
            rho  = RW'($urandom);
            mod_sel = 2'($urandom);
        end
        chk("R10", "hold lane0", lane_of(0), 10);

        // R2: mixed back-to-back stream with gaps
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            in_valid = (($urandom % 5) != 0);
            mod_sel  = 2'($urandom);
            if (($urandom % 8) == 0) begin
                z_re = ZW'($urandom);
                z_im = ZW'($urandom);
            end else begin
                z_re = ZW'(int'($urandom % 256) - 128);
                z_im = ZW'(int'($urandom % 256) - 128);
            end
            rho = RW'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule